// File: doc/BRIEF.md
# Multi-level DMA channel arbiter

This block chooses which of several DMA channels may run its next burst. A channel that is switched on and not held raises a request when its trigger fires. The request is recorded in a pending vector. A priority search over that vector picks one candidate. The search runs highest level first. Within a level it uses either lowest-index-first or a rotating order, and each level can be masked off entirely.

The candidate is promoted to the running slot only at a handover point. A handover point is any cycle where no channel is running, or where the running channel reports the end of its burst. The outgoing channel either rejoins the pending vector, if it reports remaining work, or goes idle. Descriptor handling and the data path are left to neighbouring logic. That logic watches the grant index, the grant-valid flag and the busy vector.

Top module: `dma_chan_arbiter`

## Requirements
- R1: A trigger on channel i sets `pend[i]` on the next clock edge only when `chan_en[i]` is 1 and `chan_susp[i]` is 0. A trigger in the same cycle as a suspend or a disable leaves `pend[i]` at 0.
- R2: The level of channel i is `prio[2i+1:2i]`, and 3 is the highest. A candidate on a higher enabled level is always granted before any candidate on a lower level.
- R3: A channel whose level has `lvl_en[level]` at 0 is never granted, even while it is pending.
- R4: With `lvl_rr[level]` at 0, the candidate with the lowest channel index on that level is granted.
- R5: With `lvl_rr[level]` at 1, the search on that level starts at the channel after the last channel granted on that level and wraps around. Each level keeps its own pointer. After reset the search begins at channel 0.
- R6: A handover happens in any cycle where `grant_vld` is 0 or `burst_done` is 1. At the edge that ends that cycle, the selected channel appears on `grant_idx` with `grant_vld` at 1 and its pending bit clears. A trigger on that channel in the same cycle keeps it pending. Between handovers the grant is held unchanged.
- R7: While a channel is disabled or suspended, its pending bit is 0 from the next edge on, and the channel is not granted.
- R8: When the running channel ends its burst with `more_work` at 1, and it is still enabled and not suspended, its pending bit is set. Its busy bit clears unless it is granted again.
- R9: At a handover with no eligible candidate on any enabled level, `grant_vld` goes to 0 and every rotation pointer keeps its value.
- R10: `busy` is the one-hot decode of `grant_idx` while `grant_vld` is 1, and is zero otherwise.
- R11: In reset and on leaving reset, `grant_vld` is 0, and `pend` and `busy` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | NCH | Per-channel transfer trigger |
| chan_en | input | NCH | Per-channel enable |
| chan_susp | input | NCH | Per-channel suspend |
| more_work | input | NCH | Running channel still has beats left after this burst |
| prio | input | 2*NCH | Two-bit level per channel, channel i at bits 2i+1:2i |
| lvl_en | input | 4 | Per-level enable |
| lvl_rr | input | 4 | Per-level ordering: 0 fixed, 1 rotating |
| burst_done | input | 1 | Running channel finished its burst this cycle |
| grant_idx | output | CW | Index of the running channel |
| grant_vld | output | 1 | A channel is running |
| pend | output | NCH | Pending vector |
| busy | output | NCH | One-hot running vector |

## Verification
The assertions assume that `burst_done` has meaning only while a channel is running, so a strobe with no grant is simply another handover point. They also assume that all inputs are stable across each rising edge. The bench changes every input only on the falling edge, which keeps that assumption. Its random phases pulse `burst_done` both with and without a running channel. They also flip enables, suspends and level masks mid-burst, so every assumption is exercised at its edge without being broken.

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter #(
  parameter int NCH = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    trig,
  input  logic [NCH-1:0]    chan_en,
  input  logic [NCH-1:0]    chan_susp,
  input  logic [NCH-1:0]    more_work,
  input  logic [2*NCH-1:0]  prio,
  input  logic [3:0]        lvl_en,
  input  logic [3:0]        lvl_rr,
  input  logic              burst_done,
  output logic [CW-1:0]     grant_idx,
  output logic              grant_vld,
  output logic [NCH-1:0]    pend,
  output logic [NCH-1:0]    busy
);

  logic [NCH-1:0] pend_q, elig, take_clr, ret_set, pend_d;
  logic           act_v_q;
  logic [CW-1:0]  act_i_q;
  logic [CW-1:0]  ptr_q [4];
  logic           sel_v;
  logic [CW-1:0]  sel_i;
  logic [1:0]     sel_l;
  logic           handover;
  int             c;

  assign elig     = pend_q & chan_en & ~chan_susp;
  assign handover = !act_v_q || burst_done;

  always_comb begin
    sel_v = 1'b0;
    sel_i = '0;
    sel_l = '0;
    c     = 0;
    for (int lv = 3; lv >= 0; lv--) begin
      if (!sel_v && lvl_en[lv]) begin
        for (int k = 0; k < NCH; k++) begin
          c = lvl_rr[lv] ? (int'(ptr_q[lv]) + 1 + k) % NCH : k;
          if (!sel_v && elig[c] && prio[2*c +: 2] == 2'(lv)) begin
            sel_v = 1'b1;
            sel_i = CW'(c);
            sel_l = 2'(lv);
          end
        end
      end
    end
  end

  assign take_clr = (handover && sel_v) ? (NCH'(1) << sel_i) : '0;
  assign ret_set  = (act_v_q && burst_done && more_work[act_i_q]) ? (NCH'(1) << act_i_q) : '0;
  assign pend_d   = ((pend_q & ~take_clr) | trig | ret_set) & chan_en & ~chan_susp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      act_v_q <= 1'b0;
      act_i_q <= '0;
      for (int l = 0; l < 4; l++) ptr_q[l] <= CW'(NCH - 1);
    end else begin
      pend_q <= pend_d;
      if (handover) begin
        act_v_q <= sel_v;
        if (sel_v) begin
          act_i_q      <= sel_i;
          ptr_q[sel_l] <= sel_i;
        end
      end
    end
  end

  assign grant_idx = act_i_q;
  assign grant_vld = act_v_q;
  assign pend      = pend_q;
  assign busy      = act_v_q ? (NCH'(1) << act_i_q) : '0;

  AST_BUSY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy) && (grant_vld == (busy != '0))); // R10
  AST_HOLD_MID_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && !burst_done) |=> (grant_vld && $stable(grant_idx))); // R6
  AST_IDLE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld && sel_v) |=> grant_vld); // R6
  AST_DROP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(chan_susp | ~chan_en)) == '0)); // R7
  AST_EMPTY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && burst_done && !sel_v) |=> !grant_vld); // R9

endmodule

// File: tb/test_dma_chan_arbiter.sv
`timescale 1ns/1ps
module test_dma_chan_arbiter;
  localparam int N  = 8;
  localparam int CW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]   trig = '0, chan_en = '0, chan_susp = '0, more_work = '0;
  logic [2*N-1:0] prio = '0;
  logic [3:0]     lvl_en = '0, lvl_rr = '0;
  logic           burst_done = 1'b0;
  logic [CW-1:0]  grant_idx;
  logic           grant_vld;
  logic [N-1:0]   pend, busy;

  always #2.5 clk = ~clk;

  dma_chan_arbiter #(.NCH(N)) i_dma_chan_arbiter (
    .clk(clk), .rst_n(rst_n), .trig(trig), .chan_en(chan_en), .chan_susp(chan_susp),
    .more_work(more_work), .prio(prio), .lvl_en(lvl_en), .lvl_rr(lvl_rr),
    .burst_done(burst_done), .grant_idx(grant_idx), .grant_vld(grant_vld),
    .pend(pend), .busy(busy));

  int vectors = 0, errors = 0;
  bit finished = 0;

  bit m_pend [N];
  bit m_av;
  int m_ai;
  int m_ptr [4];
  bit n_pend [N];
  bit n_av;
  int n_ai;
  int n_ptr [4];

  function automatic bit coin(int pct);
    return int'($urandom % 100) < pct;
  endfunction

  function automatic int lvl_of(int ch);
    return int'(prio[2*ch +: 2]);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_pend[i] = 0;
    m_av = 0; m_ai = 0;
    for (int l = 0; l < 4; l++) m_ptr[l] = N - 1;
  endtask

  task automatic model_step();
    bit found = 0;
    int who = 0, wlv = 0;
    bit swap = !m_av || burst_done;
    for (int lv = 3; lv >= 0 && !found; lv--) begin
      if (lvl_en[lv]) begin
        int order [$];
        if (lvl_rr[lv]) for (int k = 1; k <= N; k++) order.push_back((m_ptr[lv] + k) % N);
        else for (int k = 0; k < N; k++) order.push_back(k);
        foreach (order[j]) begin
          int ch = order[j];
          if (!found && m_pend[ch] && chan_en[ch] && !chan_susp[ch] && lvl_of(ch) == lv) begin
            found = 1; who = ch; wlv = lv;
          end
        end
      end
    end
    for (int i = 0; i < N; i++) begin
      bit p = m_pend[i];
      if (swap && found && who == i) p = 0;
      if (trig[i]) p = 1;
      if (m_av && burst_done && m_ai == i && more_work[i]) p = 1;
      if (!chan_en[i] || chan_susp[i]) p = 0;
      n_pend[i] = p;
    end
    n_av = m_av; n_ai = m_ai;
    for (int l = 0; l < 4; l++) n_ptr[l] = m_ptr[l];
    if (swap) begin
      n_av = found;
      if (found) begin n_ai = who; n_ptr[wlv] = who; end
    end
  endtask

  task automatic compare(string tag);
    logic [N-1:0] ep = '0, eb = '0;
    for (int i = 0; i < N; i++) ep[i] = m_pend[i];
    if (m_av) eb[m_ai] = 1'b1;
    vectors++;
    if (grant_vld !== m_av || (m_av && grant_idx !== CW'(m_ai))) begin
      errors++;
      $display("FAIL %s grant: got vld=%0b idx=%0d, expected vld=%0b idx=%0d",
               tag, grant_vld, grant_idx, m_av, m_ai);
    end
    if (pend !== ep) begin
      errors++;
      $display("FAIL %s pend: got %b, expected %b", tag, pend, ep);
    end
    if (busy !== eb) begin
      errors++;
      $display("FAIL %s (R10) busy: got %b, expected %b", tag, busy, eb);
    end
  endtask

  task automatic tick(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    m_pend = n_pend; m_av = n_av; m_ai = n_ai; m_ptr = n_ptr;
    compare(tag);
  endtask

  task automatic phase(string tag, int n, int p_trig, int p_susp, int p_dis, int p_done,
                       int p_more, int fix_lvl, logic [3:0] len, logic [3:0] rr);
    for (int c = 0; c < n; c++) begin
      for (int i = 0; i < N; i++) begin
        trig[i]      = coin(p_trig);
        chan_susp[i] = coin(p_susp);
        chan_en[i]   = !coin(p_dis);
        more_work[i] = coin(p_more);
        prio[2*i +: 2] = (fix_lvl < 0) ? 2'($urandom % 4) : 2'(fix_lvl);
      end
      burst_done = coin(p_done);
      lvl_en = len; lvl_rr = rr;
      tick(tag);
    end
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    vectors++;
    if (grant_vld !== 1'b0 || pend !== '0 || busy !== '0) begin
      errors++;
      $display("FAIL R11 reset: got vld=%0b pend=%b busy=%b, expected 0 0 0", grant_vld, pend, busy);
    end
    rst_n = 1'b1;
    tick("R11");
    // one cycle: trigger together with suspend on channel 2
    chan_en = '1; lvl_en = 4'hF; trig = 8'h04; chan_susp = 8'h04; tick("R1");
    trig = '0; chan_susp = '0; tick("R1");
    phase("R1", 400, 30, 10, 5, 20, 30, -1, 4'hF, 4'h0);
    phase("R2", 600, 25, 3, 3, 40, 40, -1, 4'hF, 4'h0);
    phase("R3", 600, 25, 3, 3, 40, 40, -1, 4'b0101, 4'b1010);
    phase("R4", 500, 20, 2, 2, 50, 30, 1, 4'hF, 4'h0);
    phase("R5", 800, 30, 2, 2, 60, 50, 2, 4'hF, 4'hF);
    phase("R5", 800, 30, 2, 2, 60, 50, -1, 4'hF, 4'b0110);
    phase("R7", 600, 40, 30, 20, 30, 50, -1, 4'hF, 4'hF);
    phase("R8", 600, 10, 2, 2, 70, 90, -1, 4'hF, 4'b1001);
    phase("R9", 80, 30, 2, 2, 50, 50, -1, 4'h0, 4'hF);
    phase("R9", 300, 10, 2, 2, 50, 20, 3, 4'b1000, 4'hF);
    phase("R6", 2000, 20, 5, 5, 30, 50, -1, 4'hF, 4'($urandom % 16));
    phase("R6", 2000, 50, 1, 1, 10, 70, -1, 4'hF, 4'hA);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule